// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block predicts the direction of conditional branches from two things at once: the low-order bits of the branch address and the recent taken/not-taken record of all branches executed, kept in a global history shift register. The two are concatenated into one table index. The address bits pick a row, and the history bits pick one of the 2^m saturating counters in that row. A single branch address therefore owns several independent counters, one for each recent-outcome pattern. The prediction can follow correlations between neighbouring branches, such as one branch that is always not taken whenever an earlier branch was not taken.

A fetch stage presents a branch address on the predict port and gets a combinational taken/not-taken answer, together with the history value used for that answer. When the branch resolves, the pipeline returns the same address, the history it received at prediction time, and the real outcome. The block steps the counter at that exact index up or down and shifts the outcome into the global history. The default shape has two history bits and 2-bit counters over 1024 entries.

Top module: `corr_branch_pred`

## Requirements
- R1: While reset is low and after it is released, the history reads all zeros and every counter holds the weakly-not-taken value 2^(n-1)-1, so every prediction is not taken.
- R2: pred_taken is 1 exactly when the counter at the index {pred_addr[ADDR_LSB +: ROW_W], current history} is at least 2^(n-1). pred_hist shows the history used for that index.
- R3: The row is taken only from address bits [ADDR_LSB +: ROW_W], and the history fills the low HIST_W index bits. Two addresses that differ only outside those bits share all counters.
- R4: A resolve with rslv_taken=1 raises the selected counter by one and holds it at 2^n-1 once it is there.
- R5: A resolve with rslv_taken=0 lowers the selected counter by one and holds it at 0 once it is there.
- R6: A resolve updates the counter indexed by rslv_hist, not by the current history, when the two differ.
- R7: Each resolve shifts the outcome into history bit 0 and moves the older bits up one place. The oldest bit drops out. The counter update in the same cycle still uses the history supplied on rslv_hist.
- R8: In a cycle with rslv_valid low, neither the history nor any counter changes.
- R9: One address with different history values uses separate counters, so training under one history leaves the prediction under another history unchanged.
- R10: A counter updated at a clock edge is the one seen by the predict port from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_addr | input | ADDR_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | Global history used for this prediction |
| rslv_valid | input | 1 | A resolved branch is presented this cycle |
| rslv_addr | input | ADDR_W | Address of the resolved branch |
| rslv_hist | input | HIST_W | History value returned with the resolved branch |
| rslv_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
On every cycle, the bound checker covers several properties:
- the history shift on each resolve;
- the history holding still when no resolve arrives;
- the one-step, saturating movement of the updated counter;
- the agreement of the next prediction with a counter written at the same index;
- the clean state after reset.

Correlation (R9), aliasing across rows (R3) and updates that use a returned history different from the live one (R6) concern which of many counters is touched. Only the bench's scenarios can show these. There, a behavioural model of the whole table is compared with the predict port on every clock.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;

  // One step of a saturating up/down counter bounded by [0, top].
  function automatic int unsigned sat_step(int unsigned cur, logic up, int unsigned top);
    if (up) return (cur >= top) ? top : cur + 1;
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  // Weakly-not-taken value for a counter of the given width.
  function automatic int unsigned weak_nt(int unsigned width);
    return (32'd1 << (width - 1)) - 1;
  endfunction

endpackage

// File: rtl/corr_bp_history.sv
module corr_bp_history #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_taken,
  output logic [HIST_W-1:0] hist_q
);
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W == 1) begin : g_single
      assign hist_d = push_taken;
    end else begin : g_shift
      assign hist_d = {hist_q[HIST_W-2:0], push_taken};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist_q <= '0;
    else if (push) hist_q <= hist_d;
  end
endmodule

// File: rtl/corr_bp_table.sv
module corr_bp_table #(
  parameter int IDX_W = 10,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output logic [CTR_W-1:0] upd_old,
  output logic [CTR_W-1:0] upd_new
);
  import corr_bp_pkg::*;

  localparam int          ENTRIES = 1 << IDX_W;
  localparam int unsigned CTR_MAX = (32'd1 << CTR_W) - 1;
  localparam logic [CTR_W-1:0] INIT_VAL = CTR_W'(weak_nt(CTR_W));

  logic [CTR_W-1:0] ctr_mem [ENTRIES];

  assign rd_ctr  = ctr_mem[rd_idx];
  assign upd_old = ctr_mem[wr_idx];
  assign upd_new = CTR_W'(sat_step(32'(upd_old), wr_taken, CTR_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_mem[i] <= INIT_VAL;
    end else if (wr_en) begin
      ctr_mem[wr_idx] <= upd_new;
    end
  end
endmodule

// File: rtl/corr_branch_pred.sv
module corr_branch_pred #(
  parameter int ADDR_W   = 32,
  parameter int ADDR_LSB = 2,
  parameter int ROW_W    = 8,
  parameter int HIST_W   = 2,
  parameter int CTR_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pred_addr,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              rslv_valid,
  input  logic [ADDR_W-1:0] rslv_addr,
  input  logic [HIST_W-1:0] rslv_hist,
  input  logic              rslv_taken
);
  localparam int IDX_W = ROW_W + HIST_W;

  // Address bits choose the row, history bits choose the counter within it.
  function automatic logic [IDX_W-1:0] make_idx(logic [ADDR_W-1:0] a, logic [HIST_W-1:0] h);
    return {a[ADDR_LSB +: ROW_W], h};
  endfunction

  logic [HIST_W-1:0] hist_q;
  logic [IDX_W-1:0]  pred_idx;
  logic [IDX_W-1:0]  upd_idx;
  logic [CTR_W-1:0]  rd_ctr;
  logic [CTR_W-1:0]  upd_old;
  logic [CTR_W-1:0]  upd_new;
  logic              unused_addr_bits;

  assign pred_idx = make_idx(pred_addr, hist_q);
  assign upd_idx  = make_idx(rslv_addr, rslv_hist);
  assign unused_addr_bits = ^{pred_addr, rslv_addr};

  corr_bp_history #(.HIST_W(HIST_W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (rslv_valid),
    .push_taken (rslv_taken),
    .hist_q     (hist_q)
  );

  corr_bp_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (pred_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (rslv_valid),
    .wr_idx   (upd_idx),
    .wr_taken (rslv_taken),
    .upd_old  (upd_old),
    .upd_new  (upd_new)
  );

  // Upper half of the counter range means taken.
  assign pred_taken = rd_ctr[CTR_W-1];
  assign pred_hist  = hist_q;
endmodule

// File: rtl/corr_branch_pred_chk.sv
module corr_branch_pred_chk #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rslv_valid,
  input logic              rslv_taken,
  input logic [IDX_W-1:0]  pred_idx,
  input logic [IDX_W-1:0]  upd_idx,
  input logic              pred_taken,
  input logic [HIST_W-1:0] hist_q,
  input logic [CTR_W-1:0]  upd_old,
  input logic [CTR_W-1:0]  upd_new
);
  localparam logic [HIST_W-1:0] LOW_MASK = {HIST_W{1'b1}} >> 1;
  localparam logic [CTR_W:0]    TOP      = {1'b0, {CTR_W{1'b1}}};

  // R1
  reset_clean_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (hist_q == '0) && !pred_taken);

  // R7
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rslv_valid |=> (hist_q[0] == $past(rslv_taken)) &&
                   ((hist_q >> 1) == ($past(hist_q) & LOW_MASK)));

  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rslv_valid |=> $stable(hist_q));

  // R4
  ctr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rslv_valid && rslv_taken) |->
      (({1'b0, upd_new} == {1'b0, upd_old} + 1'b1) ||
       (({1'b0, upd_old} == TOP) && ({1'b0, upd_new} == TOP))));

  // R5
  ctr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rslv_valid && !rslv_taken) |->
      (({1'b0, upd_new} + 1'b1 == {1'b0, upd_old}) ||
       ((upd_old == '0) && (upd_new == '0))));

  // R10
  pred_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rslv_valid && (upd_idx == pred_idx)) |=>
      ((pred_idx != $past(pred_idx)) || (pred_taken == $past(upd_new[CTR_W-1]))));
endmodule

bind corr_branch_pred corr_branch_pred_chk #(
  .IDX_W  (ROW_W + HIST_W),
  .HIST_W (HIST_W),
  .CTR_W  (CTR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rslv_valid (rslv_valid),
  .rslv_taken (rslv_taken),
  .pred_idx   (pred_idx),
  .upd_idx    (upd_idx),
  .pred_taken (pred_taken),
  .hist_q     (hist_q),
  .upd_old    (upd_old),
  .upd_new    (upd_new)
);

// File: tb/corr_branch_pred_tb.sv
module corr_branch_pred_tb;
  localparam int ADDR_W = 32;
  localparam int LSB    = 2;
  localparam int ROWS   = 256;
  localparam int HN     = 4;    // 2^m history patterns
  localparam int CMAX   = 3;    // 2-bit counter top
  localparam int HALF   = 2;    // taken threshold

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] pred_addr = '0;
  logic              pred_taken;
  logic [1:0]        pred_hist;
  logic              rslv_valid = 1'b0;
  logic [ADDR_W-1:0] rslv_addr = '0;
  logic [1:0]        rslv_hist = '0;
  logic              rslv_taken = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int ref_ctr[ROWS*HN];
  int ref_hist;

  always #10 clk = ~clk;   // 50 MHz

  corr_branch_pred u_dut (
    .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .rslv_valid(rslv_valid), .rslv_addr(rslv_addr),
    .rslv_hist(rslv_hist), .rslv_taken(rslv_taken)
  );

  function automatic int ref_index(logic [ADDR_W-1:0] a, int h);
    return (int'((a >> LSB) % ROWS)) * HN + h;
  endfunction

  // Behavioural reference: table of integers plus an integer history.
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (ref_ctr[i]) ref_ctr[i] = HALF - 1;
      ref_hist = 0;
    end else if (rslv_valid) begin
      int k;
      k = ref_index(rslv_addr, int'(rslv_hist));
      if (rslv_taken && ref_ctr[k] < CMAX) ref_ctr[k]++;
      else if (!rslv_taken && ref_ctr[k] > 0) ref_ctr[k]--;
      ref_hist = ((ref_hist * 2) + int'(rslv_taken)) % HN;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, compare the predict port against the model.
  task automatic cyc(string tag, logic [ADDR_W-1:0] pa, bit rv,
                     logic [ADDR_W-1:0] ra, int rh, bit rt);
    @(negedge clk);
    pred_addr  = pa;
    rslv_valid = rv;
    rslv_addr  = ra;
    rslv_hist  = 2'(rh);
    rslv_taken = rt;
    #1;
    chk({tag, " pred"}, int'(pred_taken),
        int'(ref_ctr[ref_index(pa, ref_hist)] >= HALF));
    chk({tag, " hist"}, int'(pred_hist), ref_hist);
  endtask

  localparam logic [ADDR_W-1:0] A = 32'h0000_1040;
  localparam logic [ADDR_W-1:0] B = 32'h0000_2084;

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state across several addresses
    for (int i = 0; i < 4; i++) cyc("R1", 32'(i * 52), 0, '0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) cyc("R1", 32'(i * 1234567), 0, '0, 0, 0);

    // R4 / R10: train A under history 0, bring history back to 0, predict A
    cyc("R4", A, 1, A, ref_hist, 1);
    cyc("R4", A, 1, B, ref_hist, 0);
    cyc("R4", A, 1, B, ref_hist, 0);
    cyc("R10", A, 0, '0, 0, 0);
    chk("R10 explicit", int'(pred_taken), 1);
    // R4: saturation at the top
    for (int i = 0; i < 5; i++) cyc("R4", A, 1, A, 0, 1);

    // R5: drive down past zero, then one step up must stay not taken
    for (int i = 0; i < 6; i++) cyc("R5", A, 1, A, 0, 0);
    cyc("R5", A, 1, A, 0, 1);
    cyc("R5", A, 1, B, ref_hist, 0);
    cyc("R5", A, 1, B, ref_hist, 0);
    cyc("R5", A, 0, '0, 0, 0);
    chk("R5 floor explicit", int'(pred_taken), 0);

    // R7: outcomes 1 then 0 leave history binary 10
    cyc("R7", B, 1, B, ref_hist, 1);
    cyc("R7", B, 1, B, ref_hist, 0);
    cyc("R7", B, 0, '0, 0, 0);
    chk("R7 explicit", int'(pred_hist), 2);

    // R6: update with a returned history that differs from the live one
    for (int i = 0; i < 3; i++) cyc("R6", A, 1, A, 3, 1);
    for (int i = 0; i < 4; i++) cyc("R6", A, 0, '0, 0, 0);

    // R9: same address, other histories independent
    for (int h = 0; h < HN; h++)
      for (int j = 0; j < 3; j++) cyc("R9", B + 32'(h * 4), 1, B, h, (h % 2) == 1);

    // R3: aliasing through address bits above the row field
    for (int i = 0; i < 4; i++) cyc("R3", A + 32'(ROWS * 4), 1, A + 32'(ROWS * 4 * 3), ref_hist, 1);
    for (int i = 0; i < 4; i++) cyc("R3", A + 32'(ROWS * 4 * 7) + 32'd1, 0, '0, 0, 0);

    // R8: many idle cycles with random predict addresses
    for (int i = 0; i < 200; i++) cyc("R8", $urandom, 0, $urandom, $urandom % 4, $urandom % 2);

    // R2: random traffic over a small address set, both live and stale histories
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] a;
      a = 32'(($urandom % 6) * 4);
      cyc("R2", ($urandom % 2) ? a : 32'(($urandom % 6) * 4), ($urandom % 4) != 0, a,
          ($urandom % 4 == 0) ? int'($urandom % 4) : ref_hist, ($urandom % 3) != 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule